// File: doc/BRIEF.md
# Real-Time Page Remapping Translation Buffer

This block sits between a CPU load/store port and a small on-chip SRAM. Software places whole 256-byte pages of physical memory into chosen page slots of the SRAM by writing a fully associative table with one entry per SRAM slot. Every CPU access is looked up in that table in the cycle it is accepted. A matching entry sends the access straight to the SRAM at `{slot, page offset}`. An access with no match goes out unchanged on a backing-memory port. No tags are kept in the SRAM and nothing is replaced automatically, so the outcome and latency of every access follow from the table contents alone.

The configuration port maps an entry, unmaps it, or reads back its valid and dirty bits. Software maps pages before a code or data region that reuses them. Afterwards it checks the dirty bits, writes back the pages that were modified, and unmaps them.

The CPU request channel uses valid/ready. `cpu_req_ready` is high whenever no miss is outstanding, so hits can be accepted on every cycle. A request that is held off must keep its address, write enable and write data stable. The backing request channel also uses valid/ready: `bk_req_valid` and its payload stay stable until `bk_req_ready` is seen, and `bk_rdata` is taken in that same cycle. The response channel has no ready. The CPU must take a response in the cycle it is presented.

Top module: `rtlb_remap`

## Requirements
- R1: After reset every entry is invalid and not dirty, `multi_hit_err` is 0, `cpu_req_ready` is 1, and every CPU access misses.
- R2: An accepted access whose page number (address bits 31:8) equals the stored page number of a valid entry drives `sram_en` in the same cycle, with `sram_addr` = {entry slot (5 bits), address bits 7:0}, and with `sram_we` and `sram_wdata` copied from the request. Hits may be accepted on consecutive cycles.
- R3: A hit produces `cpu_rsp_valid` with `cpu_rsp_hit`=1 exactly one cycle after acceptance. `cpu_rsp_rdata` equals `sram_rdata` in that cycle, because the SRAM returns read data one cycle after `sram_en`.
- R4: A miss never touches the SRAM. From the next cycle it raises `bk_req_valid` with the original address, write enable and write data, all held stable until `bk_req_ready`. `cpu_req_ready` stays low meanwhile. One cycle after the handshake, `cpu_rsp_valid` rises with `cpu_rsp_hit`=0 and the `bk_rdata` seen at the handshake.
- R5: A write hit sets the dirty bit of the matching entry at the edge that issues the SRAM write. Read hits and misses leave dirty bits unchanged.
- R6: `cfg_op`=1 (map) writes page number, slot and `cfg_map_valid` into entry `cfg_idx` and clears its dirty bit. This also wins over a same-cycle write hit. The new contents apply only to accesses accepted in later cycles.
- R7: `cfg_op`=2 (unmap) clears the valid bit of entry `cfg_idx`, so that page misses from the next cycle on. The dirty bit is kept so that it can be read back.
- R8: `cfg_op`=3 (read) returns, one cycle later, `cfg_rd_valid`=1 with the entry's valid and dirty bits as they stood before that edge. `cfg_op`=0 does nothing.
- R9: If several valid entries match, the lowest-index entry supplies the slot, and `multi_hit_err` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_valid | input | 1 | CPU access request valid |
| cpu_req_ready | output | 1 | Request accepted when high with valid |
| cpu_req_addr | input | 32 | Physical byte address |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | Response strobe, one cycle per access |
| cpu_rsp_hit | output | 1 | Response came from the SRAM |
| cpu_rsp_rdata | output | 32 | Read data |
| sram_en | output | 1 | SRAM access strobe |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 13 | SRAM byte address {slot, offset} |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, one cycle after sram_en |
| bk_req_valid | output | 1 | Backing-memory request valid |
| bk_req_ready | input | 1 | Backing-memory completion |
| bk_req_addr | output | 32 | Original physical address |
| bk_req_we | output | 1 | Backing write enable |
| bk_req_wdata | output | 32 | Backing write data |
| bk_rdata | input | 32 | Backing read data, valid with bk_req_ready |
| cfg_op | input | 2 | 0 none, 1 map, 2 unmap, 3 read |
| cfg_idx | input | 5 | Entry index |
| cfg_ppn | input | 24 | Physical page number for map |
| cfg_slot | input | 5 | SRAM slot for map |
| cfg_map_valid | input | 1 | Valid bit written by map |
| cfg_rd_valid | output | 1 | Readback strobe |
| cfg_rd_entry_valid | output | 1 | Read entry valid bit |
| cfg_rd_dirty | output | 1 | Read entry dirty bit |
| multi_hit_err | output | 1 | Sticky multiple-match flag |

## Verification
The properties assume that the CPU keeps a refused request unchanged and that `bk_req_ready` is only raised while `bk_req_valid` is high. They also assume that `sram_rdata` arrives one cycle after `sram_en`. The bench drives requests from a task that waits for `cpu_req_ready` with the payload held. Its backing model raises ready only on an outstanding request, after a fixed delay, and its SRAM model registers data one cycle after the strobe. Configuration indices stay inside the table. Slots differ between live entries, except in the deliberate multiple-match case.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;
  typedef enum logic [1:0] {
    CFG_NOP   = 2'd0,
    CFG_MAP   = 2'd1,
    CFG_UNMAP = 2'd2,
    CFG_READ  = 2'd3
  } cfg_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MISS = 1'b1
  } acc_state_e;
endpackage

// File: rtl/rtlb_entry_table.sv
module rtlb_entry_table
  import rtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PPN_W   = 24,
  parameter int SLOT_W  = 5,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       cfg_op,
  input  logic [IDX_W-1:0]                 cfg_idx,
  input  logic [PPN_W-1:0]                 cfg_ppn,
  input  logic [SLOT_W-1:0]                cfg_slot,
  input  logic                             cfg_map_valid,
  input  logic                             dirty_set_en,
  input  logic [IDX_W-1:0]                 dirty_set_idx,
  input  logic [PPN_W-1:0]                 lookup_ppn,
  output logic [ENTRIES-1:0]               match_vec,
  output logic [ENTRIES-1:0][SLOT_W-1:0]   slot_tab,
  output logic                             cfg_rd_valid,
  output logic                             cfg_rd_entry_valid,
  output logic                             cfg_rd_dirty
);
  cfg_op_e            op;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] dirty_vec;

  assign op = cfg_op_e'(cfg_op);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              sel;
    logic              v_q;
    logic              d_q;
    logic [PPN_W-1:0]  p_q;
    logic [SLOT_W-1:0] s_q;

    assign sel = (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (sel && op == CFG_MAP) begin
        v_q <= cfg_map_valid;
        d_q <= 1'b0;
      end else begin
        if (sel && op == CFG_UNMAP) v_q <= 1'b0;
        if (dirty_set_en && dirty_set_idx == IDX_W'(g)) d_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && op == CFG_MAP) begin
        p_q <= cfg_ppn;
        s_q <= cfg_slot;
      end
    end

    assign valid_vec[g] = v_q;
    assign dirty_vec[g] = d_q;
    assign slot_tab[g]  = s_q;
    assign match_vec[g] = v_q && (p_q == lookup_ppn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rd_valid       <= 1'b0;
      cfg_rd_entry_valid <= 1'b0;
      cfg_rd_dirty       <= 1'b0;
    end else begin
      cfg_rd_valid <= (op == CFG_READ);
      if (op == CFG_READ) begin
        cfg_rd_entry_valid <= valid_vec[cfg_idx];
        cfg_rd_dirty       <= dirty_vec[cfg_idx];
      end
    end
  end
endmodule

// File: rtl/rtlb_prio_pick.sv
module rtlb_prio_pick #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic               multi
);
  localparam logic [ENTRIES-1:0] ONE = ENTRIES'(1);

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit = |match_vec;
  assign multi   = |(match_vec & (match_vec - ONE));
endmodule

// File: rtl/rtlb_access_ctrl.sv
module rtlb_access_ctrl
  import rtlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 8,
  parameter int SLOT_W    = 5,
  localparam int SRAM_AW  = SLOT_W + PAGE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  output logic               cpu_req_ready,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic               cpu_req_we,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  output logic               cpu_rsp_valid,
  output logic               cpu_rsp_hit,
  output logic [DATA_W-1:0]  cpu_rsp_rdata,
  input  logic               any_hit,
  input  logic [SLOT_W-1:0]  hit_slot,
  output logic               accept,
  output logic               sram_en,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [DATA_W-1:0]  sram_wdata,
  input  logic [DATA_W-1:0]  sram_rdata,
  output logic               bk_req_valid,
  input  logic               bk_req_ready,
  output logic [ADDR_W-1:0]  bk_req_addr,
  output logic               bk_req_we,
  output logic [DATA_W-1:0]  bk_req_wdata,
  input  logic [DATA_W-1:0]  bk_rdata
);
  acc_state_e        state_q;
  logic              hit_q;
  logic              miss_done_q;
  logic [DATA_W-1:0] bk_data_q;

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;

  assign sram_en    = accept && any_hit;
  assign sram_we    = cpu_req_we;
  assign sram_addr  = {hit_slot, cpu_req_addr[PAGE_BITS-1:0]};
  assign sram_wdata = cpu_req_wdata;

  assign bk_req_valid = (state_q == ST_MISS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      hit_q       <= 1'b0;
      miss_done_q <= 1'b0;
      bk_data_q   <= '0;
    end else begin
      hit_q       <= sram_en;
      miss_done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept && !any_hit) state_q <= ST_MISS;
        ST_MISS: if (bk_req_ready) begin
          state_q     <= ST_IDLE;
          miss_done_q <= 1'b1;
          bk_data_q   <= bk_rdata;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !any_hit) begin
      bk_req_addr  <= cpu_req_addr;
      bk_req_we    <= cpu_req_we;
      bk_req_wdata <= cpu_req_wdata;
    end
  end

  assign cpu_rsp_valid = hit_q || miss_done_q;
  assign cpu_rsp_hit   = hit_q;
  assign cpu_rsp_rdata = hit_q ? sram_rdata : bk_data_q;
endmodule

// File: rtl/rtlb_remap.sv
module rtlb_remap
  import rtlb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_BITS  = 8,
  parameter int SRAM_BYTES = 8192,
  localparam int ENTRIES   = SRAM_BYTES >> PAGE_BITS,
  localparam int SLOT_W    = $clog2(ENTRIES),
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int PPN_W     = ADDR_W - PAGE_BITS,
  localparam int SRAM_AW   = SLOT_W + PAGE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  output logic               cpu_req_ready,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic               cpu_req_we,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  output logic               cpu_rsp_valid,
  output logic               cpu_rsp_hit,
  output logic [DATA_W-1:0]  cpu_rsp_rdata,
  output logic               sram_en,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [DATA_W-1:0]  sram_wdata,
  input  logic [DATA_W-1:0]  sram_rdata,
  output logic               bk_req_valid,
  input  logic               bk_req_ready,
  output logic [ADDR_W-1:0]  bk_req_addr,
  output logic               bk_req_we,
  output logic [DATA_W-1:0]  bk_req_wdata,
  input  logic [DATA_W-1:0]  bk_rdata,
  input  logic [1:0]         cfg_op,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [PPN_W-1:0]   cfg_ppn,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic               cfg_map_valid,
  output logic               cfg_rd_valid,
  output logic               cfg_rd_entry_valid,
  output logic               cfg_rd_dirty,
  output logic               multi_hit_err
);
  logic [ENTRIES-1:0]             match_vec;
  logic [ENTRIES-1:0][SLOT_W-1:0] slot_tab;
  logic                           any_hit;
  logic                           multi;
  logic [IDX_W-1:0]               hit_idx;
  logic [SLOT_W-1:0]              hit_slot;
  logic                           accept;
  logic                           dirty_set_en;
  logic [PPN_W-1:0]               lookup_ppn;

  assign lookup_ppn   = cpu_req_addr[ADDR_W-1:PAGE_BITS];
  assign hit_slot     = slot_tab[hit_idx];
  assign dirty_set_en = sram_en && cpu_req_we;

  rtlb_entry_table #(
    .ENTRIES(ENTRIES), .PPN_W(PPN_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_ppn(cfg_ppn),
    .cfg_slot(cfg_slot), .cfg_map_valid(cfg_map_valid),
    .dirty_set_en(dirty_set_en), .dirty_set_idx(hit_idx),
    .lookup_ppn(lookup_ppn), .match_vec(match_vec), .slot_tab(slot_tab),
    .cfg_rd_valid(cfg_rd_valid), .cfg_rd_entry_valid(cfg_rd_entry_valid),
    .cfg_rd_dirty(cfg_rd_dirty)
  );

  rtlb_prio_pick #(.ENTRIES(ENTRIES)) u_pick (
    .match_vec(match_vec), .any_hit(any_hit), .hit_idx(hit_idx), .multi(multi)
  );

  rtlb_access_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_addr(cpu_req_addr), .cpu_req_we(cpu_req_we),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .any_hit(any_hit), .hit_slot(hit_slot), .accept(accept),
    .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .bk_req_valid(bk_req_valid), .bk_req_ready(bk_req_ready),
    .bk_req_addr(bk_req_addr), .bk_req_we(bk_req_we),
    .bk_req_wdata(bk_req_wdata), .bk_rdata(bk_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) multi_hit_err <= 1'b0;
    else if (accept && multi) multi_hit_err <= 1'b1;
  end
endmodule

// File: rtl/rtlb_remap_chk.sv
module rtlb_remap_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_req_valid,
  input logic                 cpu_req_ready,
  input logic [PAGE_BITS-1:0] req_off,
  input logic                 cpu_req_we,
  input logic                 cpu_rsp_valid,
  input logic                 cpu_rsp_hit,
  input logic                 sram_en,
  input logic                 sram_we,
  input logic [PAGE_BITS-1:0] sram_off,
  input logic                 bk_req_valid,
  input logic                 bk_req_ready,
  input logic [ADDR_W-1:0]    bk_req_addr,
  input logic                 bk_req_we,
  input logic [DATA_W-1:0]    bk_req_wdata,
  input logic [1:0]           cfg_op,
  input logic                 cfg_rd_valid,
  input logic                 multi_hit_err
);
  AST_SRAM_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en |-> (cpu_req_valid && cpu_req_ready)); // R2
  AST_SRAM_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en |-> (sram_off == req_off && sram_we == cpu_req_we)); // R2
  AST_HIT_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en |=> (cpu_rsp_valid && cpu_rsp_hit)); // R3
  AST_MISS_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    bk_req_valid |-> (!cpu_req_ready && !sram_en)); // R4
  AST_BK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_req_valid && !bk_req_ready) |=> (bk_req_valid && $stable(bk_req_addr)
      && $stable(bk_req_we) && $stable(bk_req_wdata))); // R4
  AST_MISS_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_req_valid && bk_req_ready) |=> (cpu_rsp_valid && !cpu_rsp_hit && !bk_req_valid)); // R4
  AST_READBACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_op == 2'd3) |=> cfg_rd_valid); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit_err |=> multi_hit_err); // R9
endmodule

bind rtlb_remap rtlb_remap_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .req_off(cpu_req_addr[PAGE_BITS-1:0]), .cpu_req_we(cpu_req_we),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit),
  .sram_en(sram_en), .sram_we(sram_we), .sram_off(sram_addr[PAGE_BITS-1:0]),
  .bk_req_valid(bk_req_valid), .bk_req_ready(bk_req_ready),
  .bk_req_addr(bk_req_addr), .bk_req_we(bk_req_we), .bk_req_wdata(bk_req_wdata),
  .cfg_op(cfg_op), .cfg_rd_valid(cfg_rd_valid), .multi_hit_err(multi_hit_err)
);

// File: tb/tb_rtlb_remap.sv
`timescale 1ns/1ps
module tb_rtlb_remap;
  localparam int BK_DELAY = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic [31:0] cpu_req_addr = '0;
  logic        cpu_req_we = 1'b0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid, cpu_rsp_hit;
  logic [31:0] cpu_rsp_rdata;
  logic        sram_en, sram_we;
  logic [12:0] sram_addr;
  logic [31:0] sram_wdata;
  logic [31:0] sram_rdata = '0;
  logic        bk_req_valid;
  logic        bk_req_ready = 1'b0;
  logic [31:0] bk_req_addr;
  logic        bk_req_we;
  logic [31:0] bk_req_wdata;
  logic [31:0] bk_rdata = '0;
  logic [1:0]  cfg_op = 2'd0;
  logic [4:0]  cfg_idx = '0;
  logic [23:0] cfg_ppn = '0;
  logic [4:0]  cfg_slot = '0;
  logic        cfg_map_valid = 1'b0;
  logic        cfg_rd_valid, cfg_rd_entry_valid, cfg_rd_dirty;
  logic        multi_hit_err;

  int checks = 0;
  int failures = 0;

  logic        exp_hit_q[$];
  logic [31:0] exp_data_q[$];
  logic        exp_chk_q[$];
  string       exp_tag_q[$];

  logic [31:0] last_bk_addr = '0;
  logic        last_bk_we = 1'b0;
  logic [31:0] last_bk_wdata = '0;
  int          bk_wait = 0;

  always #10 clk = ~clk;

  rtlb_remap dut (.*);

  function automatic logic [31:0] sram_val(input logic [12:0] a);
    return 32'h5A00_0000 | {19'd0, a};
  endfunction
  function automatic logic [31:0] bk_val(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // SRAM model: read data one cycle after the strobe
  always @(posedge clk) if (sram_en) sram_rdata <= sram_val(sram_addr);

  // Backing model: completes an outstanding request after BK_DELAY cycles
  always @(negedge clk) begin
    bk_req_ready = 1'b0;
    if (rst_n && bk_req_valid) begin
      if (bk_wait == BK_DELAY) begin
        bk_req_ready  = 1'b1;
        bk_rdata      = bk_val(bk_req_addr);
        last_bk_addr  = bk_req_addr;
        last_bk_we    = bk_req_we;
        last_bk_wdata = bk_req_wdata;
        bk_wait = 0;
      end else bk_wait++;
    end
  end

  // Monitor: pops the scoreboard on each response
  always @(negedge clk) begin
    if (rst_n && cpu_rsp_valid) begin
      if (exp_hit_q.size() == 0) begin
        chk(32'd1, 32'd0, "R3", "unexpected response");
      end else begin
        automatic logic  eh = exp_hit_q.pop_front();
        automatic logic [31:0] ed = exp_data_q.pop_front();
        automatic logic  ec = exp_chk_q.pop_front();
        automatic string et = exp_tag_q.pop_front();
        chk({31'd0, cpu_rsp_hit}, {31'd0, eh}, et, "rsp hit flag");
        if (ec) chk(cpu_rsp_rdata, ed, et, "rsp data");
      end
    end
  end

  // Driver: issues one access and pushes its expected response
  task automatic access(input logic [31:0] a, input logic we, input logic [31:0] wd,
                        input logic exp_hit, input logic [12:0] exp_sa, input string req);
    cpu_req_valid = 1'b1;
    cpu_req_addr  = a;
    cpu_req_we    = we;
    cpu_req_wdata = wd;
    while (!cpu_req_ready) @(negedge clk);
    #1;
    chk({31'd0, sram_en}, {31'd0, exp_hit}, req, "sram_en at accept");
    if (exp_hit) begin
      chk({19'd0, sram_addr}, {19'd0, exp_sa}, req, "sram_addr");
      if (we) chk(sram_wdata, wd, req, "sram_wdata");
    end
    exp_hit_q.push_back(exp_hit);
    exp_data_q.push_back(exp_hit ? sram_val(exp_sa) : bk_val(a));
    exp_chk_q.push_back(!we);
    exp_tag_q.push_back(req);
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_hit_q.size() != 0) @(negedge clk);
  endtask

  task automatic cfg_cmd(input logic [1:0] op, input logic [4:0] idx,
                         input logic [23:0] ppn, input logic [4:0] slot);
    cfg_op = op; cfg_idx = idx; cfg_ppn = ppn; cfg_slot = slot; cfg_map_valid = 1'b1;
    @(negedge clk);
    cfg_op = 2'd0;
  endtask

  task automatic cfg_read(input logic [4:0] idx, input logic ev, input logic ed, input string req);
    cfg_op = 2'd3; cfg_idx = idx;
    @(negedge clk);
    cfg_op = 2'd0;
    chk({31'd0, cfg_rd_valid}, 32'd1, req, "readback strobe");
    chk({31'd0, cfg_rd_entry_valid}, {31'd0, ev}, req, "readback valid");
    chk({31'd0, cfg_rd_dirty}, {31'd0, ed}, req, "readback dirty");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({31'd0, cpu_req_ready}, 32'd1, "R1", "ready after reset");
    chk({31'd0, multi_hit_err}, 32'd0, "R1", "error flag after reset");
    cfg_read(5'd0, 1'b0, 1'b0, "R1");
    access(32'h0000_1234, 1'b0, '0, 1'b0, '0, "R1");
    drain();

    // R2 R3: single mapping, read hit
    cfg_cmd(2'd1, 5'd0, 24'h000012, 5'd5);
    access(32'h0000_12AB, 1'b0, '0, 1'b1, 13'h05AB, "R2");
    drain();
    cfg_read(5'd0, 1'b1, 1'b0, "R5");

    // R2 R3 R5: back-to-back hits, one write
    cfg_cmd(2'd1, 5'd31, 24'hABCDEF, 5'd0);
    cfg_cmd(2'd1, 5'd10, 24'h000400, 5'd31);
    access(32'hABCD_EF10, 1'b1, 32'h1357_9BDF, 1'b1, 13'h0010, "R5");
    access(32'h0004_0055, 1'b0, '0, 1'b1, 13'h1F55, "R3");
    access(32'h0000_12FF, 1'b0, '0, 1'b1, 13'h05FF, "R3");
    drain();
    cfg_read(5'd31, 1'b1, 1'b1, "R5");
    cfg_read(5'd10, 1'b1, 1'b0, "R5");

    // R4: write miss goes out unchanged
    access(32'h0077_7701, 1'b1, 32'h0000_CAFE, 1'b0, '0, "R4");
    drain();
    chk(last_bk_addr, 32'h0077_7701, "R4", "backing address");
    chk({31'd0, last_bk_we}, 32'd1, "R4", "backing we");
    chk(last_bk_wdata, 32'h0000_CAFE, "R4", "backing wdata");
    access(32'h0099_0010, 1'b0, '0, 1'b0, '0, "R4");
    drain();

    // R7: unmap; dirty kept
    cfg_cmd(2'd2, 5'd0, '0, '0);
    access(32'h0000_1210, 1'b0, '0, 1'b0, '0, "R7");
    drain();
    cfg_read(5'd0, 1'b0, 1'b0, "R7");
    cfg_cmd(2'd2, 5'd31, '0, '0);
    cfg_read(5'd31, 1'b0, 1'b1, "R7");

    // R6: remap clears dirty
    cfg_cmd(2'd1, 5'd31, 24'h000555, 5'd2);
    cfg_read(5'd31, 1'b1, 1'b0, "R6");

    // R6: mapping applies only to later accesses
    cfg_op = 2'd1; cfg_idx = 5'd1; cfg_ppn = 24'h000666; cfg_slot = 5'd3; cfg_map_valid = 1'b1;
    access(32'h0006_6610, 1'b0, '0, 1'b0, '0, "R6");
    cfg_op = 2'd0;
    access(32'h0006_6620, 1'b0, '0, 1'b1, 13'h0320, "R6");
    drain();

    // R9: two entries share a page; lowest index wins
    cfg_cmd(2'd1, 5'd7, 24'h000888, 5'd20);
    cfg_cmd(2'd1, 5'd4, 24'h000888, 5'd9);
    chk({31'd0, multi_hit_err}, 32'd0, "R9", "flag before access");
    access(32'h0008_8844, 1'b0, '0, 1'b1, 13'h0944, "R9");
    chk({31'd0, multi_hit_err}, 32'd1, "R9", "flag after multi match");
    cfg_cmd(2'd2, 5'd4, '0, '0);
    access(32'h0008_8845, 1'b0, '0, 1'b1, 13'h1445, "R9");
    drain();
    chk({31'd0, multi_hit_err}, 32'd1, "R9", "flag sticky");

    repeat (4) @(negedge clk);
    chk(exp_hit_q.size(), 32'd0, "R3", "scoreboard empty");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule